// File: doc/BRIEF.md
# Phase-Shiftable Post-Scale Clock Divider

This block turns a fast clock into one or more divided output clocks. Each output is placed in time with a resolution of one-eighth of a VCO period. The fast clock runs at eight times the VCO rate, so each VCO period holds eight equal slots.

Every channel picks one of the eight slots as its fine phase. It also takes a starting count, measured in whole VCO periods, as a coarse delay. Between them, these two settings can put the first output edge anywhere within the output period. A global slot offset is added to every channel and moves all outputs together. A shared mode makes every channel use the phase settings of channel 0.

The divide ratio is set by a high count and a low count, both in VCO periods. All settings are captured only on a start strobe. Changing them while the block runs therefore cannot glitch the outputs.

Top module: `ps_phase_div`

## Requirements
- R1: After reset every output is low and stays low until the first start strobe.
- R2: With D = 8*init + ((tap + gofs) mod 8) + 8*carry, where carry is 1 when tap + gofs >= 8, an output first reads high after the clock edge that comes D+1 edges after the edge that samples the start strobe.
- R3: Once running, an output is high for 8*hi fast cycles and then low for 8*lo fast cycles, so its period is 8*(hi+lo). Both hi and lo are at least 1.
- R4: Each channel applies its own tap (3-bit field tap_i[3*c+:3]) and its own init (init_i[CW*c+:CW]), independently of the other channels.
- R5: The global offset gofs_i is added to the tap of every channel. A sum of 8 or more wraps, and the wrap adds one VCO period (8 fast cycles).
- R6: When share_i is 1 at the start strobe, every channel takes the tap and init of channel 0. The hi and lo counts stay per channel.
- R7: Changes to tap, init, gofs, hi, lo or share between start strobes have no effect on the outputs.
- R8: A start strobe while running forces every output low at that edge and restarts all timing from that strobe.
- R9: For init values 0 to hi+lo-1 and taps 0 to 7, every first-edge offset from 0 to 8*(hi+lo)-1 can be reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock at eight times the VCO rate |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start/resync strobe; captures all settings |
| share_i | input | 1 | 1: all channels use channel 0 tap and init |
| gofs_i | input | 3 | Global slot offset added to every tap |
| hi_i | input | NCH*CW | Per-channel high count in VCO periods |
| lo_i | input | NCH*CW | Per-channel low count in VCO periods |
| tap_i | input | NCH*3 | Per-channel fine slot select |
| init_i | input | NCH*CW | Per-channel coarse delay in VCO periods |
| clk_o | output | NCH | Registered divided clocks |

## Verification
The assertions assume that hi and lo are never zero when a start strobe is sampled. They also assume that the strobe is a synchronous level sampled on each edge, so holding it high holds the outputs low. The bench only applies hi and lo values of 1 or more and pulses the strobe for exactly one cycle. It changes settings only at falling edges, either well clear of a strobe or deliberately between strobes, to exercise R7.

// File: rtl/ps_div_pkg.sv
package ps_div_pkg;
  localparam int TAP_W  = 3;
  localparam int NSLOT  = 1 << TAP_W;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_HIGH = 2'd2,
    ST_LOW  = 2'd3
  } ps_state_e;
endpackage

// File: rtl/ps_phase_calc.sv
module ps_phase_calc
  import ps_div_pkg::*;
#(
  parameter int CW = 4,
  localparam int DW = CW + TAP_W + 1
) (
  input  logic [TAP_W-1:0] tap_i,
  input  logic [TAP_W-1:0] gofs_i,
  input  logic [CW-1:0]    init_i,
  output logic [DW-1:0]    dly_o
);
  logic [TAP_W:0] slot_sum;
  logic [TAP_W-1:0] fine;
  logic           wrap;

  always_comb begin
    slot_sum = {1'b0, tap_i} + {1'b0, gofs_i};
    fine     = slot_sum[TAP_W-1:0];
    wrap     = slot_sum[TAP_W];
    dly_o    = DW'({init_i, {TAP_W{1'b0}}}) + DW'(fine) + DW'({wrap, {TAP_W{1'b0}}});
  end
endmodule

// File: rtl/ps_chan.sv
module ps_chan
  import ps_div_pkg::*;
#(
  parameter int CW = 4,
  localparam int DW = CW + TAP_W + 1,
  localparam int NW = CW + TAP_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [DW-1:0] dly_i,
  input  logic [CW-1:0] hi_i,
  input  logic [CW-1:0] lo_i,
  output logic          clk_o
);
  ps_state_e     st;
  logic [DW-1:0] dly_q;
  logic [NW-1:0] cnt;
  logic [CW-1:0] hi_q, lo_q;
  logic [NW-1:0] hi_len, lo_len;

  assign hi_len = {hi_q, {TAP_W{1'b0}}} - NW'(1);
  assign lo_len = {lo_q, {TAP_W{1'b0}}} - NW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      clk_o <= 1'b0;
      dly_q <= '0;
      cnt   <= '0;
      hi_q  <= '0;
      lo_q  <= '0;
    end else if (start_i) begin
      st    <= ST_WAIT;
      clk_o <= 1'b0;
      dly_q <= dly_i;
      hi_q  <= hi_i;
      lo_q  <= lo_i;
    end else begin
      unique case (st)
        ST_WAIT: begin
          if (dly_q == '0) begin
            clk_o <= 1'b1;
            st    <= ST_HIGH;
            cnt   <= hi_len;
          end else begin
            dly_q <= dly_q - DW'(1);
          end
        end
        ST_HIGH: begin
          if (cnt == '0) begin
            clk_o <= 1'b0;
            st    <= ST_LOW;
            cnt   <= lo_len;
          end else begin
            cnt <= cnt - NW'(1);
          end
        end
        ST_LOW: begin
          if (cnt == '0) begin
            clk_o <= 1'b1;
            st    <= ST_HIGH;
            cnt   <= hi_len;
          end else begin
            cnt <= cnt - NW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  p_idle_low_r1: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !clk_o);

  p_start_low_r8: assert property (@(posedge clk) disable iff (rst)
    start_i |=> !clk_o);

  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> ($stable(hi_q) && $stable(lo_q)));

  p_high_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HIGH) |-> (cnt < {hi_q, {TAP_W{1'b0}}}));

  p_rise_src_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_o) |-> ($past(st) == ST_WAIT || $past(st) == ST_LOW));
endmodule

// File: rtl/ps_phase_div.sv
module ps_phase_div
  import ps_div_pkg::*;
#(
  parameter int NCH = 2,
  parameter int CW  = 4,
  localparam int DW = CW + TAP_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               share_i,
  input  logic [TAP_W-1:0]   gofs_i,
  input  logic [NCH*CW-1:0]  hi_i,
  input  logic [NCH*CW-1:0]  lo_i,
  input  logic [NCH*TAP_W-1:0] tap_i,
  input  logic [NCH*CW-1:0]  init_i,
  output logic [NCH-1:0]     clk_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [TAP_W-1:0] tap_sel;
    logic [CW-1:0]    init_sel;
    logic [DW-1:0]    dly;

    assign tap_sel  = share_i ? tap_i[0 +: TAP_W] : tap_i[c*TAP_W +: TAP_W];
    assign init_sel = share_i ? init_i[0 +: CW]   : init_i[c*CW +: CW];

    ps_phase_calc #(.CW(CW)) u_calc (
      .tap_i  (tap_sel),
      .gofs_i (gofs_i),
      .init_i (init_sel),
      .dly_o  (dly)
    );

    ps_chan #(.CW(CW)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .start_i (start_i),
      .dly_i   (dly),
      .hi_i    (hi_i[c*CW +: CW]),
      .lo_i    (lo_i[c*CW +: CW]),
      .clk_o   (clk_o[c])
    );
  end

  p_all_low_on_start_r8: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (clk_o == '0));
endmodule

// File: tb/ps_phase_div_bench.sv
module ps_phase_div_bench;
  localparam int NCH = 2;
  localparam int CW  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, share = 1'b0;
  logic [2:0] gofs = '0;
  logic [NCH*CW-1:0] hi = '0, lo = '0, init = '0;
  logic [NCH*3-1:0]  tap = '0;
  logic [NCH-1:0]    clk_o;

  int n_chk = 0, n_fail = 0;
  int r1[NCH], f1[NCH], r2[NCH];

  always #10 clk = ~clk;

  ps_phase_div #(.NCH(NCH), .CW(CW)) u_ps_phase_div (
    .clk(clk), .rst(rst), .start_i(start), .share_i(share), .gofs_i(gofs),
    .hi_i(hi), .lo_i(lo), .tap_i(tap), .init_i(init), .clk_o(clk_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_d(input int ini, input int tp, input int g);
    int s = tp + g;
    return 8*ini + (s % 8) + ((s >= 8) ? 8 : 0);
  endfunction

  task automatic set_ch(input int c, input int h, input int l, input int tp, input int ini);
    hi[c*CW +: CW]  = CW'(h);
    lo[c*CW +: CW]  = CW'(l);
    tap[c*3 +: 3]   = 3'(tp);
    init[c*CW +: CW] = CW'(ini);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // Called at the falling edge following the start-sampling edge (k = 0)
  task automatic measure();
    logic [NCH-1:0] prev = '0;
    for (int c = 0; c < NCH; c++) begin r1[c] = -1; f1[c] = -1; r2[c] = -1; end
    for (int k = 1; k <= 400; k++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        if (clk_o[c] && !prev[c]) begin
          if (r1[c] < 0) r1[c] = k; else if (r2[c] < 0) r2[c] = k;
        end else if (!clk_o[c] && prev[c] && f1[c] < 0) f1[c] = k;
      end
      prev = clk_o;
      if (r2[0] >= 0 && r2[NCH-1] >= 0) break;
    end
  endtask

  task automatic t_reset();
    chk("R1 reset out", int'(clk_o), 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (clk_o != '0) chk("R1 idle out", int'(clk_o), 0);
    end
    chk("R1 idle after 20", int'(clk_o), 0);
  endtask

  task automatic t_sweep(input int h, input int l, input int g);
    int rt = h + l;
    gofs = 3'(g); share = 1'b0;
    for (int ini = 0; ini < rt; ini++) begin
      for (int tp = 0; tp < 8; tp++) begin
        set_ch(0, h, l, tp, ini);
        set_ch(1, l, h, 7 - tp, rt - 1 - ini);
        pulse_start();
        chk("R1 R8 low at start", int'(clk_o), 0);
        measure();
        chk(g == 0 ? "R2 R9 ch0 first edge" : "R5 ch0 first edge", r1[0], exp_d(ini, tp, g) + 1);
        chk("R3 ch0 high time", f1[0] - r1[0], 8*h);
        chk("R3 ch0 period", r2[0] - r1[0], 8*rt);
        chk("R4 ch1 first edge", r1[1], exp_d(rt - 1 - ini, 7 - tp, g) + 1);
        chk("R3 ch1 high time", f1[1] - r1[1], 8*l);
      end
    end
  endtask

  task automatic t_share();
    gofs = 3'd3;
    set_ch(0, 2, 2, 6, 1);
    set_ch(1, 1, 3, 0, 3);
    share = 1'b1;
    pulse_start();
    measure();
    chk("R6 ch0 first edge", r1[0], exp_d(1, 6, 3) + 1);
    chk("R6 ch1 uses ch0 phase", r1[1], exp_d(1, 6, 3) + 1);
    chk("R6 ch1 keeps own high", f1[1] - r1[1], 8);
    chk("R6 ch1 keeps own period", r2[1] - r1[1], 32);
    share = 1'b0;
  endtask

  task automatic t_frozen();
    gofs = 3'd0; share = 1'b0;
    set_ch(0, 2, 1, 3, 1);
    set_ch(1, 1, 1, 0, 0);
    pulse_start();
    set_ch(0, 4, 4, 7, 5);
    set_ch(1, 3, 2, 5, 2);
    gofs = 3'd6; share = 1'b1;
    measure();
    chk("R7 ch0 first edge unchanged", r1[0], exp_d(1, 3, 0) + 1);
    chk("R7 ch0 high unchanged", f1[0] - r1[0], 16);
    chk("R7 ch0 period unchanged", r2[0] - r1[0], 24);
    chk("R7 ch1 first edge unchanged", r1[1], 1);
    chk("R7 ch1 period unchanged", r2[1] - r1[1], 16);
    share = 1'b0; gofs = 3'd0;
  endtask

  task automatic t_resync();
    share = 1'b0; gofs = 3'd0;
    set_ch(0, 3, 3, 0, 0);
    set_ch(1, 3, 3, 0, 0);
    pulse_start();
    repeat (6) @(negedge clk);
    chk("R3 running high before resync", int'(clk_o), 3);
    set_ch(0, 1, 2, 5, 2);
    set_ch(1, 2, 1, 2, 0);
    pulse_start();
    chk("R8 outputs low after resync", int'(clk_o), 0);
    measure();
    chk("R8 ch0 restarted edge", r1[0], exp_d(2, 5, 0) + 1);
    chk("R8 ch0 new period", r2[0] - r1[0], 24);
    chk("R8 ch1 restarted edge", r1[1], exp_d(0, 2, 0) + 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_sweep(1, 1, 0);
    t_sweep(2, 1, 0);
    t_sweep(3, 2, 0);
    t_sweep(2, 1, 5);
    t_share();
    t_frozen();
    t_resync();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule